// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital sequencer of a 10-bit successive approximation converter. It puts a trial code on `trial_o` for an external DAC and reads a one-bit comparator decision back on `comp_i`. Holding `start_i` high arms the converter and presets the trial code to the midscale value `10'h200`. When `start_i` falls, the converter decides one bit per clock, starting at the MSB. It can resolve all ten bits, or it can stop after eight when `full_len_i` is low. Raising `start_i` again during a conversion throws that conversion away and arms the converter again.

The result is read on a tri-state bus that has two independent enables: one for the upper two bits and one for the lower eight. This lets a byte-wide host read the result in two accesses. A third enable drives the completion status onto its own tri-state pin. The clock is a plain input. `osc_run_o` shows the interval in which a free-running oscillator would have to toggle.

`start_i` is asynchronous and passes through a two-flop synchronizer. A start pulse shorter than one clock period may therefore be missed.

States:
- `ST_DONE` is the reset state and means the result is complete.
- `ST_ARM` holds the preset while start is high.
- `ST_TRIAL` resolves one bit per clock.

Transitions:
- `ST_DONE` to `ST_ARM` when synchronized start rises.
- `ST_ARM` to `ST_TRIAL` when synchronized start is low.
- `ST_TRIAL` to `ST_ARM` when start is reasserted.
- `ST_TRIAL` to `ST_DONE` once the final bit has been decided.

Top module: `sar_sequencer`

## Requirements
- R1: While synchronized start is high, the trial code is `10'h200` (bit 9 set, all others clear). This preset appears by the 3rd rising clock edge after `start_i` rises.
- R2: Conversion starts when synchronized start goes low. For a full conversion, status shows complete on the 13th rising edge after `start_i` falls and still shows in-process on the 12th. For a short conversion these edges are the 11th and the 10th.
- R3: On each trial clock, the bit under trial is kept when `comp_i` is 1 and cleared when it is 0. The next lower bit is then set. With a comparator that reports 1 exactly when trial ≤ input, the result is the input value.
- R4: Raising `start_i` during a conversion returns the sequencer to the armed preset `10'h200`. The next falling edge of start begins a fresh conversion.
- R5: `full_len_i` is sampled while the sequencer is armed. When it is 0, only bits 9 to 2 are resolved and bits 1 and 0 read 0. When it is 1, all ten bits are resolved.
- R6: With `stat_en_i` = 1, `busy_o` reads 0 while the sequencer is armed or converting and 1 when it is complete. With `stat_en_i` = 0, `busy_o` is high impedance.
- R7: `hi_en_i` = 1 drives result bits 9:8 onto `data_o[9:8]`; otherwise those pins are high impedance. `lo_en_i` does the same for bits 7:0.
- R8: `osc_run_o` is 1 from the time synchronized start rises until the conversion completes, and 0 otherwise.
- R9: After reset the sequencer is complete, the result is 0 and `osc_run_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Asynchronous convert command: high arms, falling edge starts |
| comp_i | input | 1 | Comparator decision: 1 keeps the bit under trial |
| full_len_i | input | 1 | 1 resolves 10 bits, 0 resolves 8 |
| hi_en_i | input | 1 | Drive enable for result bits 9:8 |
| lo_en_i | input | 1 | Drive enable for result bits 7:0 |
| stat_en_i | input | 1 | Drive enable for the status pin |
| trial_o | output | 10 | Trial code to the external DAC; holds the result when complete |
| data_o | output | 10 | Tri-state parallel result |
| busy_o | output | 1 | Tri-state status: 0 in process, 1 complete |
| osc_run_o | output | 1 | Clock-activity indicator |

## Verification
On every cycle, the assertions check the following: the midscale preset under start, the step from armed into trial once start drops, the restart under a reasserted start, the short-cycle stop with its two cleared low bits, and the direction of each code step against the comparator decision. The bench scenarios cover the rest. They show the exact edge on which status flips for both lengths, and they show that the final code equals the input across a table of values. They also show that the two byte enables and the status enable really float their pins (seen through pull-ups), and that a restart mid-conversion yields the result for the new input.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_DONE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_TRIAL = 2'd2
    } sar_state_t;
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
#(
    parameter int WIDTH      = 10,
    parameter int SHORT_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_s,
    input  logic             comp_i,
    input  logic             full_len_i,
    output logic [WIDTH-1:0] code_o,
    output logic             done_o,
    output logic             run_o
);
    localparam int PTR_W = $clog2(WIDTH);
    localparam logic [PTR_W-1:0] MSB_IDX   = PTR_W'(WIDTH - 1);
    localparam logic [PTR_W-1:0] SHORT_END = PTR_W'(WIDTH - SHORT_BITS);
    localparam logic [WIDTH-1:0] PRESET    = {1'b1, {(WIDTH-1){1'b0}}};

    sar_state_t       state_q, state_d;
    logic [WIDTH-1:0] code_q, code_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             len_q, len_d;
    logic [PTR_W-1:0] stop_idx;

    assign stop_idx = len_q ? '0 : SHORT_END;

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DONE;
            code_q  <= '0;
            ptr_q   <= MSB_IDX;
            len_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            ptr_q   <= ptr_d;
            len_q   <= len_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DONE:  if (start_s) state_d = ST_ARM;
            ST_ARM:   if (!start_s) state_d = ST_TRIAL;
            ST_TRIAL: begin
                if (start_s)                state_d = ST_ARM;
                else if (ptr_q == stop_idx) state_d = ST_DONE;
            end
            default:  state_d = ST_DONE;
        endcase
    end

    // trial register update
    always_comb begin
        code_d = code_q;
        ptr_d  = ptr_q;
        len_d  = len_q;
        if (start_s) begin
            code_d = PRESET;
            ptr_d  = MSB_IDX;
            len_d  = full_len_i;
        end else if (state_q == ST_TRIAL) begin
            if (!comp_i) code_d[ptr_q] = 1'b0;
            if (ptr_q != stop_idx) begin
                code_d[ptr_q - 1'b1] = 1'b1;
                ptr_d = ptr_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        code_o = code_q;
        done_o = (state_q == ST_DONE);
        run_o  = (state_q != ST_DONE);
    end

    assert_preset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_s |=> (code_q == PRESET));

    assert_arm_to_trial_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM && !start_s) |=> (state_q == ST_TRIAL));

    assert_keep_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIAL && !start_s && comp_i) |=> (code_q > $past(code_q)) || (state_q == ST_DONE));

    assert_clear_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIAL && !start_s && !comp_i) |=> (code_q < $past(code_q)));

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIAL && start_s) |=> (state_q == ST_ARM));

    assert_short_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIAL && !start_s && !len_q && ptr_q == SHORT_END)
            |=> (state_q == ST_DONE && code_q[1:0] == 2'b00));

    assert_run_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> $past(start_s));
endmodule

// File: rtl/sar_bus_drv.sv
module sar_bus_drv #(
    parameter int WIDTH  = 10,
    parameter int LO_W   = 8
) (
    input  logic [WIDTH-1:0] code_i,
    input  logic             done_i,
    input  logic             hi_en_i,
    input  logic             lo_en_i,
    input  logic             stat_en_i,
    output logic [WIDTH-1:0] data_o,
    output logic             busy_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i >= LO_W) begin : g_hi
            assign data_o[i] = hi_en_i ? code_i[i] : 1'bz;
        end else begin : g_lo
            assign data_o[i] = lo_en_i ? code_i[i] : 1'bz;
        end
    end

    assign busy_o = stat_en_i ? done_i : 1'bz;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
    parameter int WIDTH       = 10,
    parameter int SHORT_BITS  = 8,
    parameter int LO_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             comp_i,
    input  logic             full_len_i,
    input  logic             hi_en_i,
    input  logic             lo_en_i,
    input  logic             stat_en_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] data_o,
    output logic             busy_o,
    output logic             osc_run_o
);
    logic start_s;
    logic done;

    sar_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (start_i),
        .sync_o  (start_s)
    );

    sar_fsm #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_s    (start_s),
        .comp_i     (comp_i),
        .full_len_i (full_len_i),
        .code_o     (trial_o),
        .done_o     (done),
        .run_o      (osc_run_o)
    );

    sar_bus_drv #(.WIDTH(WIDTH), .LO_W(LO_W)) u_bus (
        .code_i    (trial_o),
        .done_i    (done),
        .hi_en_i   (hi_en_i),
        .lo_en_i   (lo_en_i),
        .stat_en_i (stat_en_i),
        .data_o    (data_o),
        .busy_o    (busy_o)
    );

    assert_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_en_i && osc_run_o) |-> (busy_o == 1'b0));
endmodule

// File: tb/sar_sequencer_bench.sv
module sar_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       full_len_i = 1'b1;
    logic       hi_en_i = 1'b0;
    logic       lo_en_i = 1'b0;
    logic       stat_en_i = 1'b0;
    logic [9:0] vin = '0;
    logic       comp_i;
    logic [9:0] trial_o;
    wire  [9:0] data_w;
    wire        busy_w;
    logic       osc_run_o;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    // comparator model: 1 when trial does not exceed the input
    assign comp_i = (trial_o <= vin);

    for (genvar i = 0; i < 10; i++) begin : g_pu
        pullup (data_w[i]);
    end
    pullup (busy_w);

    sar_sequencer u_sar_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .comp_i     (comp_i),
        .full_len_i (full_len_i),
        .hi_en_i    (hi_en_i),
        .lo_en_i    (lo_en_i),
        .stat_en_i  (stat_en_i),
        .trial_o    (trial_o),
        .data_o     (data_w),
        .busy_o     (busy_w),
        .osc_run_o  (osc_run_o)
    );

    // {full, vin, expected}
    localparam int NVEC = 8;
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b1, 10'h3FF, 10'h3FF},
        {1'b1, 10'h000, 10'h000},
        {1'b1, 10'h200, 10'h200},
        {1'b1, 10'h1FF, 10'h1FF},
        {1'b1, 10'h155, 10'h155},
        {1'b0, 10'h3FF, 10'h3FC},
        {1'b0, 10'h003, 10'h000},
        {1'b0, 10'h2A7, 10'h2A4}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_conv(input bit full, input logic [9:0] v, input logic [9:0] exp);
        int n;
        vin = v;
        full_len_i = full;
        @(negedge clk);
        start_i = 1'b1;
        repeat (4) @(negedge clk);
        check(trial_o == 10'h200, "R1 preset", int'(trial_o), 'h200);
        check(osc_run_o == 1'b1, "R8 run while armed", int'(osc_run_o), 1);
        start_i = 1'b0;
        n = full ? 12 : 10;
        stat_en_i = 1'b1;
        repeat (n) @(negedge clk);
        check(busy_w == 1'b0, "R2 R6 still in process", int'(busy_w), 0);
        @(negedge clk);
        check(busy_w == 1'b1, "R2 R6 complete", int'(busy_w), 1);
        check(osc_run_o == 1'b0, "R8 stopped", int'(osc_run_o), 0);
        hi_en_i = 1'b1; lo_en_i = 1'b1;
        #1;
        check(data_w == exp, full ? "R3 result" : "R5 short result", int'(data_w), int'(exp));
        hi_en_i = 1'b1; lo_en_i = 1'b0;
        #1;
        check(data_w == {exp[9:8], 8'hFF}, "R7 high only", int'(data_w), int'({exp[9:8], 8'hFF}));
        hi_en_i = 1'b0; lo_en_i = 1'b1;
        #1;
        check(data_w == {2'b11, exp[7:0]}, "R7 low only", int'(data_w), int'({2'b11, exp[7:0]}));
        lo_en_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        stat_en_i = 1'b1; hi_en_i = 1'b1; lo_en_i = 1'b1;
        #1;
        check(data_w == 10'h000, "R9 result after reset", int'(data_w), 0);
        check(busy_w == 1'b1, "R9 complete after reset", int'(busy_w), 1);
        check(osc_run_o == 1'b0, "R9 no run after reset", int'(osc_run_o), 0);
        rst_n = 1'b1;
        hi_en_i = 1'b0; lo_en_i = 1'b0; stat_en_i = 1'b0;
        @(negedge clk);

        for (int k = 0; k < NVEC; k++) begin
            run_conv(VEC[k][20], VEC[k][19:10], VEC[k][9:0]);
        end

        // R6: status floats when disabled during a conversion
        vin = 10'h0F0; full_len_i = 1'b1;
        start_i = 1'b1;
        repeat (4) @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        stat_en_i = 1'b0;
        #1;
        check(busy_w == 1'b1, "R6 status floats", int'(busy_w), 1);
        stat_en_i = 1'b1;
        #1;
        check(busy_w == 1'b0, "R6 status driven in process", int'(busy_w), 0);

        // R4: restart mid-conversion with a new input
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        check(trial_o == 10'h200, "R4 restart preset", int'(trial_o), 'h200);
        check(busy_w == 1'b0, "R4 restart in process", int'(busy_w), 0);
        vin = 10'h0AB;
        start_i = 1'b0;
        repeat (13) @(negedge clk);
        hi_en_i = 1'b1; lo_en_i = 1'b1;
        #1;
        check(busy_w == 1'b1, "R4 restart complete", int'(busy_w), 1);
        check(data_w == 10'h0AB, "R4 restart result", int'(data_w), 'h0AB);
        hi_en_i = 1'b0; lo_en_i = 1'b0;

        // R7: both enables low float the whole bus
        #1;
        check(data_w == 10'h3FF, "R7 bus floats", int'(data_w), 'h3FF);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule